// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

A register-mapped controller for a bank of general-purpose pins, 95 by default. Software reaches it through a plain word-wide read/write port. Every pin owns two configuration words:

- The first word sets the pin's use (native function or GPIO), its direction, its output level and its interrupt trigger, and it returns the sampled input level.
- The second word gates input sensing and picks a weak-pull setting. The pull setting goes out on per-pin pull-up and pull-down selects for the pad logic.

Four shared bitmaps pack 32 pins per word: ownership, redirection routing, interrupt status and interrupt enable.

Each pad input passes through a two-stage synchroniser. The synchronised value feeds edge or level detection. A detected event sets the pin's status bit. Software clears status by writing ones to it. One combined interrupt line is high whenever any status bit is set while its enable bit is also set.

Top module: `gpio_bank`

## Requirements
- R1: After reset every config word 1 reads 0x0000_0004 (native use, input) and every config word 2 reads 0x0000_0004 (sensing off, no pull). Enable and status read 0, ownership reads all ones for existing pins, route reads 0, and irq_o, pad_oe_o and both pull outputs are low.
- R2: Config word 1 of pin p is at byte address 0x100+8p and config word 2 is at 0x104+8p. Bitmap word k is at base+4k, with bases ownership 0x00, route 0x10, status 0x80 and enable 0x90. Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.
- R3: Config word 1 holds:
  - bit 31: output level
  - bit 30: read-only sampled input
  - bit 4: trigger select
  - bit 3: invert
  - bit 2: direction (1 = input)
  - bits 1:0: use (1 = GPIO)

  Config word 2 holds bit 2 (sensing disabled) and bits 1:0 (pull). All other bits read 0.
- R4: pad_oe_o of a pin is high only when its use field is 1 and its direction bit is 0. pad_out_o follows bit 31.
- R5: Pull field 1 raises pull_dn_o, 2 raises pull_up_o, and 0 or 3 raises neither.
- R6: The sampled input (bit 30) follows the pad through two register stages. It reads 0 while sensing is disabled.
- R7: Trigger {bit4,bit3} = 00 sets status once on a rising edge. irq_o rises on the third clock edge after the pad change, and a falling edge has no effect.
- R8: Trigger 01 sets status on a falling edge, with the same latency as R7.
- R9: Trigger 11 (high) and 10 (low) set status on every cycle the level holds, with the same latency as R7. A clear written while the level holds leaves the bit set.
- R10: Writing a status word clears the bits written as 1 and leaves the bits written as 0 unchanged. When the same pin has an event in that cycle, the set wins.
- R11: irq_o is the OR of status AND enable. A masked status bit stays readable and does not raise irq_o.
- R12: A pin whose ownership bit is 0 never sets its status bit.
- R13: A pin with sensing disabled raises no event.
- R14: Bitmap bits above the last pin read 0 and ignore writes. Addresses of pins beyond the last pin read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe, data valid after next edge |
| reg_addr_i | input | ADDR_W (10) | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PINS | Output level per pin |
| pad_oe_o | output | NUM_PINS | Output enable per pin |
| pull_up_o | output | NUM_PINS | Weak pull-up select |
| pull_dn_o | output | NUM_PINS | Weak pull-down select |
| irq_o | output | 1 | Combined interrupt |

## Verification
A stale previous-level register or a synchroniser with a missing stage shows up directly on irq_o. The line rises one cycle early or late relative to the third edge after the pad change, or an edge-mode pin fires again after its status was cleared. Corrupted configuration state appears at once on pad_oe_o and on the pull selects, or on the next read of the config word. A wrong status update (lost set priority, a clear applied to the wrong word, or an event from a reserved pin) shows in the status word read one cycle after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned CFG_BASE  = 32'h100;
  localparam int unsigned OFF_OWN   = 32'h00;
  localparam int unsigned OFF_ROUTE = 32'h10;
  localparam int unsigned OFF_STAT  = 32'h80;
  localparam int unsigned OFF_EN    = 32'h90;

  localparam logic [1:0] USE_GPIO = 2'd1;
  localparam logic [1:0] PULL_DN  = 2'd1;
  localparam logic [1:0] PULL_UP  = 2'd2;

  // {select, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  typedef struct packed {
    logic       out_lvl;
    trig_e      trig;
    logic       dir_in;
    logic [1:0] use_sel;
  } cfg1_t;

  typedef struct packed {
    logic       sense_dis;
    logic [1:0] pull;
  } cfg2_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we1_i,
  input  logic        we2_i,
  input  cfg1_t       wr1_i,
  input  cfg2_t       wr2_i,
  input  logic        sync_i,
  output logic [31:0] cfg1_o,
  output logic [31:0] cfg2_o,
  output logic        event_o,
  output logic        pad_out_o,
  output logic        pad_oe_o,
  output logic        pull_up_o,
  output logic        pull_dn_o
);
  cfg1_t cfg1_q;
  cfg2_t cfg2_q;
  logic  prev_q;
  logic  hit;
  logic  lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= '{out_lvl: 1'b0, trig: TRIG_RISE, dir_in: 1'b1, use_sel: 2'd0};
      cfg2_q <= '{sense_dis: 1'b1, pull: 2'd0};
      prev_q <= 1'b0;
    end else begin
      if (we1_i) cfg1_q <= wr1_i;
      if (we2_i) cfg2_q <= wr2_i;
      // tracks the raw synchronised level so gating sensing fabricates no edge
      prev_q <= sync_i;
    end
  end

  always_comb begin
    unique case (cfg1_q.trig)
      TRIG_RISE: hit = sync_i & ~prev_q;
      TRIG_FALL: hit = ~sync_i & prev_q;
      TRIG_LOW:  hit = ~sync_i;
      TRIG_HIGH: hit = sync_i;
      default:   hit = 1'b0;
    endcase
  end

  assign lvl       = sync_i & ~cfg2_q.sense_dis;
  assign event_o   = hit & ~cfg2_q.sense_dis;
  assign cfg1_o    = {cfg1_q.out_lvl, lvl, 25'd0, cfg1_q.trig, cfg1_q.dir_in, cfg1_q.use_sel};
  assign cfg2_o    = {29'd0, cfg2_q.sense_dis, cfg2_q.pull};
  assign pad_out_o = cfg1_q.out_lvl;
  assign pad_oe_o  = (cfg1_q.use_sel == USE_GPIO) && !cfg1_q.dir_in;
  assign pull_up_o = (cfg2_q.pull == PULL_UP);
  assign pull_dn_o = (cfg2_q.pull == PULL_DN);

  assert_edge_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg1_q.trig[1] && event_o && !we1_i) |=> !event_o)
    else $error("edge trigger fired on consecutive cycles");

  assert_gated_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg2_q.sense_dis |-> (!event_o && !cfg1_o[30]))
    else $error("event or level seen with sensing disabled");

  assert_oe_drives_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |-> (cfg1_o[2] == 1'b0))
    else $error("output enabled on an input pin");

endmodule

// File: rtl/gpio_bank_bitmaps.sv
module gpio_bank_bitmaps #(
  parameter int unsigned NUM_PINS = 95,
  parameter int unsigned NWORDS   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_own_i,
  input  logic                we_route_i,
  input  logic                we_en_i,
  input  logic                we_stat_i,
  input  logic [1:0]          widx_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_PINS-1:0] event_i,
  output logic [NUM_PINS-1:0] own_o,
  output logic [NUM_PINS-1:0] route_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] stat_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] wbit, wsel, clr, ev_own;
  logic [NUM_PINS-1:0] own_q, route_q, en_q, stat_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    assign wbit[i] = wdata_i[i % 32];
    assign wsel[i] = (32'(widx_i) == (i / 32));
  end

  assign clr    = we_stat_i ? (wsel & wbit) : '0;
  assign ev_own = event_i & own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '1;
      route_q <= '0;
      en_q    <= '0;
      stat_q  <= '0;
    end else begin
      if (we_own_i)   own_q   <= (own_q   & ~wsel) | (wbit & wsel);
      if (we_route_i) route_q <= (route_q & ~wsel) | (wbit & wsel);
      if (we_en_i)    en_q    <= (en_q    & ~wsel) | (wbit & wsel);
      // set beats clear so a persisting level keeps its bit
      stat_q <= (stat_q & ~clr) | ev_own;
    end
  end

  assign own_o   = own_q;
  assign route_o = route_q;
  assign en_o    = en_q;
  assign stat_o  = stat_q;
  assign irq_o   = |(stat_q & en_q);

  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr) & ~$past(ev_own)) == '0))
    else $error("cleared status bit survived");

  assert_reserved_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(own_q)) == '0))
    else $error("reserved pin set status");

  assert_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o)
    else $error("irq with all enables clear");

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 95,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic                irq_o
);
  localparam int unsigned NWORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned EXT_W  = NWORDS * 32;
  localparam int unsigned PIN_W  = ADDR_W - 3;

  logic [NUM_PINS-1:0]       sync;
  logic [NUM_PINS-1:0]       events;
  logic [NUM_PINS-1:0][31:0] cfg1_all, cfg2_all;
  logic [NUM_PINS-1:0]       own, route, en, stat;
  logic [EXT_W-1:0]          own_x, route_x, en_x, stat_x;

  logic [ADDR_W-1:0] off;
  logic [PIN_W-1:0]  pin_idx;
  logic              aligned, pin_ok, cfg_hi;
  logic              hit_own, hit_route, hit_en, hit_stat;
  logic [1:0]        widx;
  logic [31:0]       rd_next, rdata_q;
  cfg1_t             wr1;
  cfg2_t             wr2;

  function automatic logic bm_hit(input logic [ADDR_W-1:0] a, input int unsigned base);
    logic [31:0] b;
    b = base;
    return (a[ADDR_W-1:4] == b[ADDR_W-1:4]) && (a[1:0] == 2'b00) &&
           (32'(a[3:2]) < NWORDS);
  endfunction

  // decode
  assign aligned   = (reg_addr_i[1:0] == 2'b00);
  assign off       = reg_addr_i - ADDR_W'(CFG_BASE);
  assign pin_idx   = off[ADDR_W-1:3];
  assign cfg_hi    = off[2];
  assign pin_ok    = aligned && (reg_addr_i >= ADDR_W'(CFG_BASE)) && (32'(pin_idx) < NUM_PINS);
  assign hit_own   = bm_hit(reg_addr_i, OFF_OWN);
  assign hit_route = bm_hit(reg_addr_i, OFF_ROUTE);
  assign hit_en    = bm_hit(reg_addr_i, OFF_EN);
  assign hit_stat  = bm_hit(reg_addr_i, OFF_STAT);
  assign widx      = reg_addr_i[3:2];

  assign wr1 = '{out_lvl: reg_wdata_i[31], trig: trig_e'(reg_wdata_i[4:3]),
                 dir_in: reg_wdata_i[2], use_sel: reg_wdata_i[1:0]};
  assign wr2 = '{sense_dis: reg_wdata_i[2], pull: reg_wdata_i[1:0]};

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel = reg_we_i && pin_ok && (32'(pin_idx) == p);

    gpio_bank_pin u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we1_i     (sel && !cfg_hi),
      .we2_i     (sel && cfg_hi),
      .wr1_i     (wr1),
      .wr2_i     (wr2),
      .sync_i    (sync[p]),
      .cfg1_o    (cfg1_all[p]),
      .cfg2_o    (cfg2_all[p]),
      .event_o   (events[p]),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .pull_up_o (pull_up_o[p]),
      .pull_dn_o (pull_dn_o[p])
    );
  end

  gpio_bank_bitmaps #(.NUM_PINS(NUM_PINS), .NWORDS(NWORDS)) u_bitmaps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_own_i   (reg_we_i && hit_own),
    .we_route_i (reg_we_i && hit_route),
    .we_en_i    (reg_we_i && hit_en),
    .we_stat_i  (reg_we_i && hit_stat),
    .widx_i     (widx),
    .wdata_i    (reg_wdata_i),
    .event_i    (events),
    .own_o      (own),
    .route_o    (route),
    .en_o       (en),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  assign own_x   = EXT_W'(own);
  assign route_x = EXT_W'(route);
  assign en_x    = EXT_W'(en);
  assign stat_x  = EXT_W'(stat);

  always_comb begin
    rd_next = '0;
    if (pin_ok)         rd_next = cfg_hi ? cfg2_all[pin_idx] : cfg1_all[pin_idx];
    else if (hit_own)   rd_next = own_x[{widx, 5'd0} +: 32];
    else if (hit_route) rd_next = route_x[{widx, 5'd0} +: 32];
    else if (hit_en)    rd_next = en_x[{widx, 5'd0} +: 32];
    else if (hit_stat)  rd_next = stat_x[{widx, 5'd0} +: 32];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_next;
  end

  assign reg_rdata_o = rdata_q;

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !pin_ok && !hit_own && !hit_route && !hit_en && !hit_stat) |=> (reg_rdata_o == '0))
    else $error("unmapped read returned data");

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int unsigned NP = 95;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pads = '0;
  logic [NP-1:0] pad_out, pad_oe, pull_up, pull_dn;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(10)) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .reg_we_i (reg_we), .reg_re_i (reg_re), .reg_addr_i (reg_addr),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
    .pad_in_i (pads), .pad_out_o (pad_out), .pad_oe_o (pad_oe),
    .pull_up_o (pull_up), .pull_dn_o (pull_dn), .irq_o (irq)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'h128, 32'hFFFF_FFFF, 32'h0},          // pin 5 cfg1, R3
    '{1'b0, 10'h128, 32'h0,         32'h8000_001F},
    '{1'b0, 10'h12C, 32'h0,         32'h0000_0004},  // pin 5 cfg2 untouched
    '{1'b1, 10'h3F4, 32'hFFFF_FFFF, 32'h0},          // pin 94 cfg2
    '{1'b0, 10'h3F4, 32'h0,         32'h0000_0007},
    '{1'b1, 10'h098, 32'hFFFF_FFFF, 32'h0},          // enable word 2, R14
    '{1'b0, 10'h098, 32'h0,         32'h7FFF_FFFF},
    '{1'b1, 10'h010, 32'hA5A5_A5A5, 32'h0},          // route word 0
    '{1'b0, 10'h010, 32'h0,         32'hA5A5_A5A5},
    '{1'b0, 10'h040, 32'h0,         32'h0},          // unmapped, R2
    '{1'b1, 10'h3F8, 32'hFFFF_FFFF, 32'h0},          // pin 95 absent
    '{1'b0, 10'h3F8, 32'h0,         32'h0},
    '{1'b1, 10'h008, 32'h0,         32'h0},          // ownership word 2
    '{1'b0, 10'h008, 32'h0,         32'h0},
    '{1'b1, 10'h008, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 10'h008, 32'h0,         32'h7FFF_FFFF},
    '{1'b1, 10'h12A, 32'h0,         32'h0},          // misaligned write ignored
    '{1'b0, 10'h12A, 32'h0,         32'h0},
    '{1'b0, 10'h128, 32'h0,         32'h8000_001F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
  endtask

  task automatic check_reset();
    logic [31:0] r;
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pad_oe", 32'(|pad_oe), 32'h0);
    check("R1 pulls", 32'(|(pull_up | pull_dn)), 32'h0);
    reg_read(10'h128, r); check("R1 cfg1 pin5", r, 32'h4);
    reg_read(10'h12C, r); check("R1 cfg2 pin5", r, 32'h4);
    reg_read(10'h008, r); check("R1 own word2", r, 32'h7FFF_FFFF);
    reg_read(10'h098, r); check("R1 enable word2", r, 32'h0);
    reg_read(10'h080, r); check("R1 status word0", r, 32'h0);
    reg_read(10'h010, r); check("R1 route word0", r, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    rst_ni = 1'b1;
    check_reset();

    // map and field table: R2, R3, R14
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) reg_write(VECS[k].addr, VECS[k].data);
      else begin
        reg_read(VECS[k].addr, r);
        check($sformatf("R2/R3/R14 vector %0d", k), r, VECS[k].exp);
      end
    end

    do_reset();
    check_reset();

    // R7 rising edge on pin 3
    reg_write(10'h118, 32'h0000_0005);
    reg_write(10'h11C, 32'h0);
    reg_write(10'h090, 32'h0000_0008);
    pads[3] = 1'b1;
    tick(2); check("R7 irq before third edge", 32'(irq), 32'h0);
    tick(1); check("R7 irq at third edge", 32'(irq), 32'h1);
    reg_read(10'h080, r); check("R7 status", r, 32'h0000_0008);
    reg_read(10'h118, r); check("R6 sampled level", r, 32'h4000_0005);
    reg_write(10'h080, 32'h0000_0008);
    check("R10 irq after clear", 32'(irq), 32'h0);
    tick(3);
    reg_read(10'h080, r); check("R7 no refire while high", r, 32'h0);
    pads[3] = 1'b0;
    tick(4);
    reg_read(10'h080, r); check("R7 falling ignored", r, 32'h0);

    // R8 falling edge on pin 40
    pads[40] = 1'b1;
    tick(4);
    reg_write(10'h240, 32'h0000_000D);
    reg_write(10'h244, 32'h0);
    reg_write(10'h094, 32'h0000_0100);
    reg_read(10'h084, r); check("R8 no event on high", r, 32'h0);
    pads[40] = 1'b0;
    tick(2); check("R8 irq before third edge", 32'(irq), 32'h0);
    tick(1); check("R8 irq at third edge", 32'(irq), 32'h1);
    reg_read(10'h084, r); check("R8 status", r, 32'h0000_0100);
    reg_write(10'h084, 32'hFFFF_FEFF);
    reg_read(10'h084, r); check("R10 zero bits kept", r, 32'h0000_0100);
    reg_write(10'h084, 32'h0000_0100);
    reg_read(10'h084, r); check("R10 one bit cleared", r, 32'h0);

    // R9 level high on pin 70
    reg_write(10'h330, 32'h0000_001D);
    reg_write(10'h334, 32'h0);
    reg_write(10'h098, 32'h0000_0040);
    pads[70] = 1'b1;
    tick(2); check("R9 irq before third edge", 32'(irq), 32'h0);
    tick(1); check("R9 irq at third edge", 32'(irq), 32'h1);
    reg_write(10'h088, 32'h0000_0040);
    reg_read(10'h088, r); check("R9 clear while high", r, 32'h0000_0040);
    pads[70] = 1'b0;
    tick(3);
    reg_write(10'h088, 32'h0000_0040);
    reg_read(10'h088, r); check("R9 clear after release", r, 32'h0);
    check("R9 irq low", 32'(irq), 32'h0);

    // R9 level low on pin 10, R11 masking
    reg_write(10'h150, 32'h0000_0015);
    reg_write(10'h154, 32'h0);
    reg_read(10'h080, r); check("R9 level low status", r, 32'h0000_0400);
    check("R11 masked irq", 32'(irq), 32'h0);
    reg_write(10'h090, 32'h0000_0408);
    check("R11 unmasked irq", 32'(irq), 32'h1);
    pads[10] = 1'b1;
    tick(3);
    reg_write(10'h080, 32'h0000_0400);
    reg_read(10'h080, r); check("R9 level low released", r, 32'h0);

    // R12 reserved pin 20
    reg_write(10'h000, 32'hFFEF_FFFF);
    reg_write(10'h1A0, 32'h0000_0005);
    reg_write(10'h1A4, 32'h0);
    reg_write(10'h090, 32'h0010_0408);
    pads[20] = 1'b1;
    tick(4);
    reg_read(10'h080, r); check("R12 reserved status", r, 32'h0);
    check("R12 irq", 32'(irq), 32'h0);

    // R13 sensing disabled on pin 21
    reg_write(10'h1A8, 32'h0000_0005);
    reg_write(10'h1AC, 32'h0000_0004);
    reg_write(10'h090, 32'h0030_0408);
    pads[21] = 1'b1;
    tick(4);
    reg_read(10'h080, r); check("R13 no event", r, 32'h0);
    reg_read(10'h1A8, r); check("R6 gated level", r, 32'h0000_0005);

    // R4 output enable on pin 50
    reg_write(10'h290, 32'h8000_0001);
    check("R4 oe gpio output", 32'(pad_oe[50]), 32'h1);
    check("R4 out level", 32'(pad_out[50]), 32'h1);
    reg_write(10'h290, 32'h8000_0005);
    check("R4 oe input", 32'(pad_oe[50]), 32'h0);
    reg_write(10'h290, 32'h8000_0000);
    check("R4 oe native", 32'(pad_oe[50]), 32'h0);

    // R5 pulls on pin 60
    reg_write(10'h2E4, 32'h1);
    check("R5 pull down", {30'd0, pull_up[60], pull_dn[60]}, 32'h1);
    reg_write(10'h2E4, 32'h2);
    check("R5 pull up", {30'd0, pull_up[60], pull_dn[60]}, 32'h2);
    reg_write(10'h2E4, 32'h3);
    check("R5 pull none", {30'd0, pull_up[60], pull_dn[60]}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule